// File: doc/BRIEF.md
# Seconds Counter with Coherent Split Reads

This block keeps a 48-bit count of elapsed seconds. A one-cycle pulse arrives at 32768 Hz, and a prescaler turns these pulses into one step of the count per second. Software sees the count through two 32-bit words on a simple register bus. The low word holds bits 31:0 of the count, and bits 15:0 of the high word hold bits 47:32. Writing either word loads that part of the count.

A read of the two words can straddle a carry out of the low word. To make such a read coherent, a freeze mode can be selected. In that mode a read of the low word copies the upper 16 bits of the count into a snapshot. The next read of the high word returns the snapshot and releases it. Software then gets a consistent 48-bit time in two reads with no retry loop, provided it always reads the low word first.

A 48-bit alarm value is compared with the count. When the count steps onto the alarm value, the alarm sets a raw status bit. An external event input sets a second raw status bit. A masked status register, a write-one-to-clear path, and separate write-one set and clear enable registers produce one level-high interrupt line.

Top module: `rtc_seconds`

## Requirements
- R1: After reset the count, the alarm value, the control field, the raw status, the enables and `irq` are all zero, and every register reads 0.
- R2: The count advances by exactly one after every TICKS_PER_SEC cycles in which `tick` is high. Cycles with `tick` low do not advance the count or the prescaler.
- R3: A read at 0x08 returns count bits 31:0. A read at 0x0C returns count bits 47:32 in bits 15:0 and zero in bits 31:16.
- R4: The control register is at 0x50, with the freeze mode in bits 25:24. With mode 2'b10, a low-word read captures count bits 47:32, and the following high-word read returns the captured value and releases it. In any other mode, or when no capture is held, the high-word read returns the live count.
- R5: A write to 0x08 loads count bits 31:0. A write to 0x0C loads count bits 47:32 from wdata bits 15:0 and ignores wdata bits 31:16. Either write restarts the prescaler, so the next step comes a full TICKS_PER_SEC ticks later. A write wins over a step in the same cycle.
- R6: The alarm value is written and read at 0x20 (bits 31:0) and 0x24 (bits 47:32 in bits 15:0). Raw status bit 0 is set at the step on which the count becomes equal to the alarm value, and is not set again while the count stays there.
- R7: A cycle with `alt_evt` high sets raw status bit 1. Raw status reads at 0x54, and writes to 0x54 have no effect.
- R8: A read at 0x58 returns raw status AND enable. Writing 1 to a bit at 0x58 clears that raw bit. If an event sets the same bit in the same cycle, the event wins.
- R9: Writing 1s at 0x5C sets enable bits, and writing 1s at 0x60 clears them. Zeros have no effect. A read at either address returns the enable bits in bits 1:0.
- R10: `irq` is high exactly when some bit is set in both the raw status and the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at the 32768 Hz rate |
| alt_evt | input | 1 | Alternate event; sets raw status bit 1 |
| sel | input | 1 | Bus access in this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench loads the count at 0x1_FFFF_FFFF and reads the low word. It then steps the count past the carry and reads the high word. In freeze mode the high word must still show 1. A design with no snapshot would return 2 and produce a time about 136 years off. The same sequence in mode 0 must return 2, which catches a snapshot that is applied in every mode. The bench holds the count on the alarm value after clearing the status, to catch an alarm that retriggers on every cycle of equality. It also drives a clear and an event into the same status bit in one cycle, to catch a design that loses the event. Randomly chosen load values and tick counts check the prescaler period and that the high-word write ignores its upper bits.

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SEC_W         = 48,
  parameter int DW            = 32,
  parameter int AW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          alt_evt,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int PW = $clog2(TICKS_PER_SEC);
  localparam int HW = SEC_W - DW;
  localparam int FM_LSB = 24;
  localparam logic [1:0] FM_FREEZE = 2'b10;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_SEC - 1);

  localparam logic [AW-1:0] A_TLO  = AW'(8'h08);
  localparam logic [AW-1:0] A_THI  = AW'(8'h0C);
  localparam logic [AW-1:0] A_MLO  = AW'(8'h20);
  localparam logic [AW-1:0] A_MHI  = AW'(8'h24);
  localparam logic [AW-1:0] A_CTL  = AW'(8'h50);
  localparam logic [AW-1:0] A_RAW  = AW'(8'h54);
  localparam logic [AW-1:0] A_STAT = AW'(8'h58);
  localparam logic [AW-1:0] A_ENS  = AW'(8'h5C);
  localparam logic [AW-1:0] A_ENC  = AW'(8'h60);

  logic [SEC_W-1:0] secs, alarm;
  logic [PW-1:0]    presc;
  logic [HW-1:0]    hi_snap;
  logic             frozen;
  logic [1:0]       fmode;
  logic [1:0]       raw, en;

  wire rd_stb = sel & ~wr;
  wire wr_stb = sel & wr;
  wire wr_lo  = wr_stb && addr == A_TLO;
  wire wr_hi  = wr_stb && addr == A_THI;
  wire rd_lo  = rd_stb && addr == A_TLO;
  wire rd_hi  = rd_stb && addr == A_THI;
  wire loadw  = wr_lo | wr_hi;
  wire step   = tick && presc == PRE_LAST && !loadw;
  wire [SEC_W-1:0] secs_inc = secs + SEC_W'(1);
  wire alarm_hit = step && secs_inc == alarm;
  wire [1:0] stat_clr = (wr_stb && addr == A_STAT) ? wdata[1:0] : 2'b00;
  wire [1:0] set_ev = {alt_evt, alarm_hit};
  wire use_snap = fmode == FM_FREEZE && frozen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secs <= '0; presc <= '0; alarm <= '0;
      hi_snap <= '0; frozen <= 1'b0; fmode <= 2'b00;
      raw <= 2'b00; en <= 2'b00;
    end else begin
      if (loadw) begin
        presc <= '0;
        if (wr_lo) secs[DW-1:0] <= wdata;
        if (wr_hi) secs[SEC_W-1:DW] <= wdata[HW-1:0];
      end else if (tick) begin
        presc <= (presc == PRE_LAST) ? '0 : presc + PW'(1);
        if (step) secs <= secs_inc;
      end
      if (rd_lo && fmode == FM_FREEZE) begin
        hi_snap <= secs[SEC_W-1:DW];
        frozen  <= 1'b1;
      end else if (rd_hi) begin
        frozen <= 1'b0;
      end
      if (wr_stb && addr == A_MLO) alarm[DW-1:0] <= wdata;
      if (wr_stb && addr == A_MHI) alarm[SEC_W-1:DW] <= wdata[HW-1:0];
      if (wr_stb && addr == A_CTL) fmode <= wdata[FM_LSB+1:FM_LSB];
      raw <= (raw & ~stat_clr) | set_ev;
      if (wr_stb && addr == A_ENS) en <= en | wdata[1:0];
      else if (wr_stb && addr == A_ENC) en <= en & ~wdata[1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_TLO:  rdata = secs[DW-1:0];
      A_THI:  rdata[HW-1:0] = use_snap ? hi_snap : secs[SEC_W-1:DW];
      A_MLO:  rdata = alarm[DW-1:0];
      A_MHI:  rdata[HW-1:0] = alarm[SEC_W-1:DW];
      A_CTL:  rdata[FM_LSB+1:FM_LSB] = fmode;
      A_RAW:  rdata[1:0] = raw;
      A_STAT: rdata[1:0] = raw & en;
      A_ENS, A_ENC: rdata[1:0] = en;
      default: rdata = '0;
    endcase
  end

  assign irq = |(raw & en);
endmodule

// File: rtl/rtc_seconds_chk.sv
module rtc_seconds_chk #(
  parameter int SEC_W = 48,
  parameter int HW    = 16,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             alt_evt,
  input logic             sel,
  input logic             wr,
  input logic [AW-1:0]    addr,
  input logic [1:0]       wbits,
  input logic             irq,
  input logic [SEC_W-1:0] secs,
  input logic [SEC_W-1:0] alarm,
  input logic [HW-1:0]    hi_snap,
  input logic             frozen,
  input logic [1:0]       raw,
  input logic [1:0]       en
);
  wire time_wr = sel && wr && (addr == AW'(8'h08) || addr == AW'(8'h0C));
  wire lo_rd   = sel && !wr && addr == AW'(8'h08);

  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !time_wr) |=> $stable(secs));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!time_wr && tick) |=> (secs == $past(secs) || secs == $past(secs) + SEC_W'(1)));

  assert_snap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !lo_rd) |=> $stable(hi_snap));

  assert_alarm_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[0]) |-> secs == alarm);

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alt_evt |=> raw[1]);

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == AW'(8'h58) && wbits[1] && !alt_evt) |=> !raw[1]);

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en != 2'b00 && raw != 2'b00));
endmodule

bind rtc_seconds rtc_seconds_chk #(.SEC_W(SEC_W), .HW(HW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .alt_evt(alt_evt), .sel(sel), .wr(wr),
  .addr(addr), .wbits(wdata[1:0]), .irq(irq), .secs(secs), .alarm(alarm),
  .hi_snap(hi_snap), .frozen(frozen), .raw(raw), .en(en)
);

// File: tb/sim_rtc_seconds.sv
module sim_rtc_seconds;
  localparam int T = 4;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, alt_evt = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_seconds #(.TICKS_PER_SEC(T)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .alt_evt(alt_evt), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [47:0] exp_time(input logic [47:0] v, input int k);
    return v + 48'(k / T);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic wrr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic load(input logic [47:0] v);
    wrr(8'h0C, {16'hBEEF, v[47:32]});
    wrr(8'h08, v[31:0]);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    logic [31:0] d, lo, hi;
    logic [47:0] v;
    int k, s;
    s = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    foreach (addr_list[i]) begin
      rd(addr_list[i], d);
      chk("R1 reset read", d, 0);
    end
    chk("R1 irq", irq, 0);

    // R2 idle cycles do not count
    repeat (20) @(negedge clk);
    rd(8'h08, d); chk("R2 idle", d, 0);
    ticks(T - 1); rd(8'h08, d); chk("R2 before period", d, 0);
    ticks(1); rd(8'h08, d); chk("R2 one second", d, 1);

    // R4 freeze across carry
    wrr(8'h50, 32'h0200_0000);
    rd(8'h50, d); chk("R4 ctrl readback", d, 32'h0200_0000);
    load(48'h1_FFFF_FFFF);
    rd(8'h08, d); chk("R3 low word", d, 32'hFFFF_FFFF);
    ticks(T);
    rd(8'h0C, d); chk("R4 frozen high", d, 1);
    rd(8'h0C, d); chk("R4 released high", d, 2);
    rd(8'h08, d); chk("R3 low after carry", d, 0);
    // R4 mode 0: live high word
    wrr(8'h50, 0);
    load(48'h1_FFFF_FFFF);
    rd(8'h08, d);
    ticks(T);
    rd(8'h0C, d); chk("R4 live high mode0", d, 2);

    // R5 write restarts prescaler and ignores upper bits
    wrr(8'h50, 32'h0200_0000);
    load(48'h0);
    ticks(T - 1);
    load(48'h0000_0000_0010);
    ticks(T - 1); rd(8'h08, d); chk("R5 prescaler restart", d, 32'h10);
    ticks(1); rd(8'h08, d); chk("R5 step after restart", d, 32'h11);

    // R3/R5 random loads and tick counts
    for (int it = 0; it < 24; it++) begin
      v = {16'($urandom), $urandom};
      k = $urandom_range(0, 3 * T);
      load(v);
      ticks(k);
      rd(8'h08, lo); rd(8'h0C, hi);
      chk("R5 random load+count", {16'h0, hi[15:0], lo}, {16'h0, exp_time(v, k)});
      chk("R3 high upper zero", hi[31:16], 0);
    end

    // R6 alarm
    wrr(8'h5C, 32'hFFFF_FFFF);  // R9 set both enables
    rd(8'h5C, d); chk("R9 enable set read", d, 3);
    rd(8'h60, d); chk("R9 enable clr read", d, 3);
    wrr(8'h58, 3);
    v = {16'($urandom), $urandom};
    v[47:32] = 16'h0000;
    wrr(8'h20, v[31:0] + 32'd3);
    wrr(8'h24, 32'hFFFF_0000 | 32'(v[47:32]));
    rd(8'h20, d); chk("R6 alarm lo read", d, v[31:0] + 32'd3);
    rd(8'h24, d); chk("R6 alarm hi read", d, 32'(v[47:32]));
    load(v);
    ticks(3 * T - 1);
    rd(8'h54, d); chk("R6 no early alarm", d, 0);
    chk("R10 irq low early", irq, 0);
    ticks(1);
    rd(8'h54, d); chk("R6 alarm raw set", d, 1);
    chk("R10 irq on alarm", irq, 1);
    wrr(8'h58, 1);
    ticks(T - 1);
    rd(8'h54, d); chk("R6 no retrigger", d, 0);
    chk("R10 irq after clear", irq, 0);

    // R7/R8 alternate event, race with clear
    @(negedge clk); alt_evt = 1; @(negedge clk); alt_evt = 0;
    rd(8'h54, d); chk("R7 alt raw", d, 2);
    wrr(8'h54, 0);
    rd(8'h54, d); chk("R7 raw write ignored", d, 2);
    @(negedge clk); sel = 1; wr = 1; addr = 8'h58; wdata = 2; alt_evt = 1;
    @(negedge clk); sel = 0; wr = 0; alt_evt = 0;
    rd(8'h54, d); chk("R8 event wins clear", d, 2);
    wrr(8'h60, 2);
    rd(8'h5C, d); chk("R9 enable clear", d, 1);
    rd(8'h58, d); chk("R8 masked status", d, 0);
    chk("R10 irq masked off", irq, 0);
    wrr(8'h5C, 2);
    rd(8'h58, d); chk("R8 masked status on", d, 2);
    chk("R10 irq masked on", irq, 1);
    wrr(8'h58, 2);
    rd(8'h58, d); chk("R8 w1c", d, 0);
    chk("R10 irq cleared", irq, 0);
    summary();
  end

  logic [7:0] addr_list [9] = '{8'h08, 8'h0C, 8'h20, 8'h24, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h60};
endmodule